// File: doc/BRIEF.md
# Four-Bit Slice ALU with Cascade Outputs

This block is a purely combinational arithmetic and logic slice for one four-bit nibble. Two operands, a four-bit function select and a mode input choose one of 32 operations. With the mode input high, each result bit is an independent bitwise function of the matching operand bits. With it low, the slice becomes an adder whose two addends are formed from the operands according to the select, and the carry chain is live.

Wider datapaths are built from several slices. Either the active-low carry output ripples into the next slice's carry input, or the active-low group propagate and group generate outputs feed an external lookahead unit. An equality flag is the AND of the result bits. Subtract mode with no carry in turns it into an operand comparator.

The slice has no clock and holds no state. It carries no data stream, so it has no valid/ready handshake and cannot apply back-pressure. Every output is a settled function of the present inputs only.

Top module: `slice_alu`

## Requirements
- R1: With `logic_mode_i`=1, `res_o` follows the bitwise table: sel 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A. `carry_in_n_i` has no effect on `res_o`.
- R2: With `logic_mode_i`=0 and sel 1001, {~`carry_out_n_o`, `res_o`} equals A + B + c, where c = ~`carry_in_n_i`. The carry input and carry output are active low.
- R3: With `logic_mode_i`=0 and sel 0110, `res_o` equals A + ~B + c. This is A-B-1 with `carry_in_n_i`=1 and A-B with `carry_in_n_i`=0. `carry_out_n_o` is low exactly when that five-bit sum exceeds 15.
- R4: With `logic_mode_i`=0, the result and carry out are X + Y + c, with (X, Y) per sel: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (0,15), 0100 (A,A&~B), 0101 (A|B,A&~B), 0111 (A&~B,15), 1000 (A,A&B), 1010 (A|~B,A&B), 1011 (A&B,15), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,15). This includes transfer of A (0000) and decrement of A (1111).
- R5: `carry_out_n_o` depends on operands, select and carry input but not on `logic_mode_i`. In logic mode it equals the arithmetic-mode value for the same inputs.
- R6: `grp_gen_n_o` is low exactly when the slice produces a carry out with `carry_in_n_i`=1.
- R7: `grp_prop_n_o` is low when every bit position would pass an incoming carry. Whenever the slice generates no carry by itself, `carry_out_n_o` with a carry in equals `grp_prop_n_o`. For sel 1001 in arithmetic mode, it is low exactly when A|B is all ones.
- R8: `eq_o` is 1 exactly when all four bits of `res_o` are 1. In arithmetic mode with sel 0110 and `carry_in_n_i`=1, it is 1 exactly when A equals B.
- R9: The slice is combinational. Outputs reflect new inputs without any clock edge, and a repeated input gives the same outputs whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4 | Operand A |
| opb_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select |
| logic_mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in_n_i | input | 1 | Active-low carry into bit 0 |
| res_o | output | 4 | Function result |
| carry_out_n_o | output | 1 | Active-low ripple carry out of bit 3 |
| grp_prop_n_o | output | 1 | Active-low group propagate for lookahead |
| grp_gen_n_o | output | 1 | Active-low group generate for lookahead |
| eq_o | output | 1 | All result bits high |

## Verification
The bench targets the active-low carry polarity, where an inverted carry input makes every add off by one and makes subtraction without forced carry land on A-B instead of A-B-1. It sweeps every select in both modes over all operand pairs and both carry inputs. This exposes any mistake in the addend table, any carry leaking into logic-mode results, and any mode gating of the carry output. Group generate and propagate are checked against the carries the slice actually produces, so an error in the lookahead product terms shows up as a wrong group signal on operand pairs where the ripple result is right. An eight-bit add built from two passes through the slice checks that the carry output chains correctly.

// File: rtl/slice_alu_pkg.sv
`timescale 1ns/1ps
package slice_alu_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic prop;
    logic gen;
    logic half;
  } bit_terms_t;
endpackage

// File: rtl/slice_alu_cell.sv
`timescale 1ns/1ps
// Per-bit term former: builds propagate, generate and half-sum from one
// operand bit pair under the function select.
module slice_alu_cell
  import slice_alu_pkg::*;
(
  input  logic             a_i,
  input  logic             b_i,
  input  logic [SEL_W-1:0] sel_i,
  output bit_terms_t       terms_o
);
  logic b_pass;
  logic b_inv;

  always_comb begin
    b_pass       = b_i & sel_i[0];
    b_inv        = ~b_i & sel_i[1];
    terms_o.prop = a_i | b_pass | b_inv;
    terms_o.gen  = a_i & ((b_i & sel_i[3]) | (~b_i & sel_i[2]));
    // gen implies prop, so prop & ~gen is the exclusive-or of the addends
    terms_o.half = terms_o.prop & ~terms_o.gen;
  end
endmodule

// File: rtl/slice_alu_lookahead.sv
`timescale 1ns/1ps
// Flat carry lookahead: every carry is a two-level sum of products.
module slice_alu_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] gen_i,
  input  logic         cin_i,
  output logic [W-1:0] carry_o,
  output logic         cout_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);
  logic [W:0] carries;

  always_comb begin
    logic acc;
    logic term;
    carries = '0;
    for (int i = 0; i <= W; i++) begin
      acc = cin_i;
      for (int j = 0; j < i; j++) acc = acc & prop_i[j];
      for (int j = 0; j < i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k < i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      carries[i] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < W; k++) term = term & prop_i[k];
      acc = acc | term;
    end
    grp_gen_o = acc;
  end

  assign grp_prop_o = &prop_i;
  assign carry_o    = carries[W-1:0];
  assign cout_o     = carries[W];
endmodule

// File: rtl/slice_alu_sum.sv
`timescale 1ns/1ps
// Result stage: merges half-sums with carries (arithmetic) or forces the
// inverted half-sum (logic), then decodes the all-ones flag.
module slice_alu_sum #(
  parameter int W = 4
) (
  input  logic [W-1:0] half_i,
  input  logic [W-1:0] carry_i,
  input  logic         logic_mode_i,
  output logic [W-1:0] res_o,
  output logic         all_ones_o
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign res_o[gi] = half_i[gi] ^ (logic_mode_i | carry_i[gi]);
    end
  endgenerate

  assign all_ones_o = &res_o;
endmodule

// File: rtl/slice_alu.sv
`timescale 1ns/1ps
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             logic_mode_i,
  input  logic             carry_in_n_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_out_n_o,
  output logic             grp_prop_n_o,
  output logic             grp_gen_n_o,
  output logic             eq_o
);
  bit_terms_t [WIDTH-1:0] terms;
  logic [WIDTH-1:0] prop_v;
  logic [WIDTH-1:0] gen_v;
  logic [WIDTH-1:0] half_v;
  logic [WIDTH-1:0] carry_v;
  logic             cout_hi;
  logic             gp_hi;
  logic             gg_hi;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_cell
      slice_alu_cell u_cell (
        .a_i     (opa_i[gi]),
        .b_i     (opb_i[gi]),
        .sel_i   (sel_i),
        .terms_o (terms[gi])
      );
      assign prop_v[gi] = terms[gi].prop;
      assign gen_v[gi]  = terms[gi].gen;
      assign half_v[gi] = terms[gi].half;
    end
  endgenerate

  slice_alu_lookahead #(.W(WIDTH)) u_cla (
    .prop_i     (prop_v),
    .gen_i      (gen_v),
    .cin_i      (~carry_in_n_i),
    .carry_o    (carry_v),
    .cout_o     (cout_hi),
    .grp_prop_o (gp_hi),
    .grp_gen_o  (gg_hi)
  );

  slice_alu_sum #(.W(WIDTH)) u_sum (
    .half_i       (half_v),
    .carry_i      (carry_v),
    .logic_mode_i (logic_mode_i),
    .res_o        (res_o),
    .all_ones_o   (eq_o)
  );

  assign carry_out_n_o = ~cout_hi;
  assign grp_prop_n_o  = ~gp_hi;
  assign grp_gen_n_o   = ~gg_hi;
endmodule

// File: rtl/slice_alu_chk.sv
`timescale 1ns/1ps
module slice_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   sel_i,
  input logic         logic_mode_i,
  input logic         carry_in_n_i,
  input logic [W-1:0] res_o,
  input logic         carry_out_n_o,
  input logic         grp_prop_n_o,
  input logic         grp_gen_n_o,
  input logic         eq_o
);
  logic [W:0] add_ref;
  logic [W:0] sub_ref;
  logic [W:0] got;

  always_comb begin
    add_ref = {1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, ~carry_in_n_i};
    sub_ref = {1'b0, opa_i} + {1'b0, ~opb_i} + {{W{1'b0}}, ~carry_in_n_i};
    got     = {~carry_out_n_o, res_o};
    if (!$isunknown({opa_i, opb_i, sel_i, logic_mode_i, carry_in_n_i})) begin
      if (!logic_mode_i && sel_i == 4'b1001)
        AST_ADD_SUM: assert (got == add_ref) else $error("add mismatch"); // R2
      if (!logic_mode_i && sel_i == 4'b0110)
        AST_SUB_SUM: assert (got == sub_ref) else $error("sub mismatch"); // R3
      if (logic_mode_i && sel_i == 4'b0110)
        AST_LOGIC_XOR: assert (res_o == (opa_i ^ opb_i)) else $error("xor mismatch"); // R1
      if (!logic_mode_i && sel_i == 4'b0110 && carry_in_n_i)
        AST_EQ_COMPARE: assert (eq_o == (opa_i == opb_i)) else $error("eq mismatch"); // R8
      AST_GROUP_CARRY: assert (~carry_out_n_o == (~grp_gen_n_o | (~grp_prop_n_o & ~carry_in_n_i)))
        else $error("group/carry mismatch"); // R7
    end
  end
endmodule

bind slice_alu slice_alu_chk #(.W(WIDTH)) u_chk (
  .opa_i         (opa_i),
  .opb_i         (opb_i),
  .sel_i         (sel_i),
  .logic_mode_i  (logic_mode_i),
  .carry_in_n_i  (carry_in_n_i),
  .res_o         (res_o),
  .carry_out_n_o (carry_out_n_o),
  .grp_prop_n_o  (grp_prop_n_o),
  .grp_gen_n_o   (grp_gen_n_o),
  .eq_o          (eq_o)
);

// File: tb/sim_slice_alu.sv
`timescale 1ns/1ps
module sim_slice_alu;
  logic       clk = 1'b0;
  logic [3:0] opa, opb, sel;
  logic       mode, cin_n;
  logic [3:0] res;
  logic       cout_n, gp_n, gg_n, eq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  slice_alu u0 (
    .opa_i (opa), .opb_i (opb), .sel_i (sel),
    .logic_mode_i (mode), .carry_in_n_i (cin_n),
    .res_o (res), .carry_out_n_o (cout_n),
    .grp_prop_n_o (gp_n), .grp_gen_n_o (gg_n), .eq_o (eq)
  );

  // Addends (X, Y) of the arithmetic table, five bits wide
  function automatic logic [9:0] addends(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    logic [3:0] x, y;
    case (s)
      4'b0000: begin x = a;       y = 4'h0;   end
      4'b0001: begin x = a | b;   y = 4'h0;   end
      4'b0010: begin x = a | ~b;  y = 4'h0;   end
      4'b0011: begin x = 4'h0;    y = 4'hF;   end
      4'b0100: begin x = a;       y = a & ~b; end
      4'b0101: begin x = a | b;   y = a & ~b; end
      4'b0110: begin x = a;       y = ~b;     end
      4'b0111: begin x = a & ~b;  y = 4'hF;   end
      4'b1000: begin x = a;       y = a & b;  end
      4'b1001: begin x = a;       y = b;      end
      4'b1010: begin x = a | ~b;  y = a & b;  end
      4'b1011: begin x = a & b;   y = 4'hF;   end
      4'b1100: begin x = a;       y = a;      end
      4'b1101: begin x = a | b;   y = a;      end
      4'b1110: begin x = a | ~b;  y = a;      end
      default: begin x = a;       y = 4'hF;   end
    endcase
    return {1'b0, x, 1'b0, y};
  endfunction

  function automatic logic [4:0] arith_ref(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b, input logic c);
    logic [9:0] xy;
    xy = addends(s, a, b);
    return xy[9:5] + xy[4:0] + {4'b0, c};
  endfunction

  function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'b0000: return ~a;
      4'b0001: return ~(a | b);
      4'b0010: return ~a & b;
      4'b0011: return 4'h0;
      4'b0100: return ~(a & b);
      4'b0101: return ~b;
      4'b0110: return a ^ b;
      4'b0111: return a & ~b;
      4'b1000: return ~a | b;
      4'b1001: return ~(a ^ b);
      4'b1010: return b;
      4'b1011: return a & b;
      4'b1100: return 4'hF;
      4'b1101: return a | ~b;
      4'b1110: return a | b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h s=%b m=%b cn=%b)",
               tag, got, exp, opa, opb, sel, mode, cin_n);
    end
  endtask

  task automatic apply(input logic m, input logic [3:0] s, input logic [3:0] a, input logic [3:0] b, input logic cn);
    @(negedge clk);
    mode = m; sel = s; opa = a; opb = b; cin_n = cn;
    #5;
  endtask

  task automatic t_idle_inputs;
    apply(1'b1, 4'b0000, 4'h0, 4'h0, 1'b1);
    check("R1 idle not-A", {4'h0, res}, 8'h0F);
    check("R8 idle eq", {7'h0, eq}, 8'h01);
  endtask

  task automatic t_add_directed;
    apply(1'b0, 4'b1001, 4'h7, 4'h8, 1'b1);
    check("R2 7+8", {3'h0, ~cout_n, res}, 8'h0F);
    apply(1'b0, 4'b1001, 4'h7, 4'h8, 1'b0);
    check("R2 7+8+1", {3'h0, ~cout_n, res}, 8'h10);
    apply(1'b0, 4'b1001, 4'hF, 4'hF, 1'b0);
    check("R2 F+F+1", {3'h0, ~cout_n, res}, 8'h1F);
  endtask

  task automatic t_sub_and_compare;
    apply(1'b0, 4'b0110, 4'h9, 4'h3, 1'b0);
    check("R3 9-3", {3'h0, ~cout_n, res}, 8'h16);
    apply(1'b0, 4'b0110, 4'h3, 4'h9, 1'b0);
    check("R3 3-9 borrow", {3'h0, ~cout_n, res}, 8'h0A);
    apply(1'b0, 4'b0110, 4'h5, 4'h5, 1'b1);
    check("R8 equal operands", {7'h0, eq}, 8'h01);
    check("R3 5-5-1", {4'h0, res}, 8'h0F);
    apply(1'b0, 4'b0110, 4'h5, 4'h4, 1'b1);
    check("R8 unequal operands", {7'h0, eq}, 8'h00);
  endtask

  task automatic t_transfer_decrement;
    apply(1'b0, 4'b0000, 4'hA, 4'h3, 1'b1);
    check("R4 transfer A", {4'h0, res}, 8'h0A);
    apply(1'b0, 4'b1111, 4'h0, 4'h3, 1'b1);
    check("R4 decrement 0", {3'h0, ~cout_n, res}, 8'h0F);
    apply(1'b0, 4'b1111, 4'h6, 4'h3, 1'b1);
    check("R4 decrement 6", {3'h0, ~cout_n, res}, 8'h15);
  endtask

  task automatic t_cascade8;
    logic c_mid;
    logic [3:0] lo;
    // 0xB7 + 0x5C + 1 = 0x114 via two slice passes
    apply(1'b0, 4'b1001, 4'h7, 4'hC, 1'b0);
    lo = res; c_mid = cout_n;
    apply(1'b0, 4'b1001, 4'hB, 4'h5, c_mid);
    check("R2 cascade 8-bit", {res, lo}, 8'h14);
    check("R2 cascade carry", {7'h0, ~cout_n}, 8'h01);
  endtask

  task automatic t_no_state;
    logic [3:0] first;
    apply(1'b0, 4'b1001, 4'h3, 4'h4, 1'b1);
    first = res;
    opa = 4'hE; opb = 4'h1; #1;
    check("R9 immediate response", {4'h0, res}, 8'h0F);
    opa = 4'h3; opb = 4'h4; #1;
    check("R9 repeat same result", {4'h0, res}, {4'h0, first});
  endtask

  task automatic t_full_sweep;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int cn = 0; cn < 2; cn++) begin
              logic [4:0] ar, a0, a1;
              logic [3:0] fexp;
              apply(m[0], s[3:0], a[3:0], b[3:0], cn[0]);
              ar = arith_ref(s[3:0], a[3:0], b[3:0], ~cn[0]);
              a0 = arith_ref(s[3:0], a[3:0], b[3:0], 1'b0);
              a1 = arith_ref(s[3:0], a[3:0], b[3:0], 1'b1);
              fexp = m[0] ? logic_ref(s[3:0], a[3:0], b[3:0]) : ar[3:0];
              if (m[0]) check("R1 logic result", {4'h0, res}, {4'h0, fexp});
              else      check("R4 arith result", {4'h0, res}, {4'h0, fexp});
              check("R5 carry out", {7'h0, cout_n}, {7'h0, ~ar[4]});
              check("R6 group generate", {7'h0, gg_n}, {7'h0, ~a0[4]});
              if (!a0[4]) check("R7 group propagate", {7'h0, gp_n}, {7'h0, ~a1[4]});
              if (!m[0] && s == 9)
                check("R7 add propagate", {7'h0, gp_n}, {7'h0, ~&(a[3:0] | b[3:0])});
              check("R8 eq flag", {7'h0, eq}, {7'h0, &fexp});
            end
  endtask

  initial begin
    opa = '0; opb = '0; sel = '0; mode = 1'b1; cin_n = 1'b1;
    t_idle_inputs();
    t_add_directed();
    t_sub_and_compare();
    t_transfer_decrement();
    t_cascade8();
    t_no_state();
    t_full_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule